// File: doc/BRIEF.md
# Split-Capable Bus Slave Responder

This block is the reply side of a slave on a pipelined system bus. When it is selected, it takes a transfer in the address phase. That needs the bus-wide ready to be high and a non-sequential or sequential transfer type. In the data phase that follows, it drives its own ready line and a two-bit response. Test-control inputs choose the answer for each transfer: a normal completion after some wait cycles, a retry, a split, or an error. A small array of registers holds the written data and returns it on reads.

When built as split-capable, the slave can park one master at a time. It records that master's number during the split reply. When the resume input is raised, it sends a one-cycle pulse on that master's bit of an eight-bit release vector. A slave built without the capability turns every split request into a retry. A slave that already holds a split does the same.

Top module: `splitSlaveResp`

## Requirements
- R1: A transfer answered OKAY ends in the cycle where `readyOut` is high and `respOut` is 2'b00. A write stores `wdataIn` (sampled in that cycle) into word `addrIn[2:0]`. A read returns that word on `rdataOut` in that cycle.
- R2: The wait request `waitIn` = n with mode 2'b00 (OKAY) holds `readyOut` low with `respOut` 2'b00 for exactly n data-phase cycles, then raises `readyOut`.
- R3: Modes 2'b01 (ERROR → resp 2'b01), 2'b10 (RETRY → resp 2'b10) and 2'b11 (SPLIT → resp 2'b11) answer over two cycles. In the first, `readyOut` is low with the code. In the second, `readyOut` is high with the same code.
- R4: With `SPLIT_CAP` = 0, a SPLIT request is answered with RETRY (2'b10), and resp 2'b11 never appears.
- R5: After an ERROR answer, sequential transfers (`transIn` 2'b11) are ignored until a non-sequential (2'b10) or idle (2'b00) transfer is seen. An ignored beat causes no wait and no write.
- R6: While a split is held, a further SPLIT request is answered with RETRY.
- R7: Raising `resumeIn` while a split is held sets only the bit of `splitVecOut` indexed by the `masterIn` value captured with the split, in the cycle after. With no split held, `resumeIn` leaves `splitVecOut` at zero.
- R8: A release pulse lasts one cycle, even if `resumeIn` stays high, and frees the slave to split again.
- R9: A wait request above 16 is clamped to 16 wait cycles.
- R10: After reset, `readyOut` is 1, `respOut` is 2'b00 and `splitVecOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| selIn | input | 1 | Slave selected for the current address phase |
| transIn | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| writeIn | input | 1 | 1 for write, 0 for read |
| addrIn | input | ADDR_W | Address; low bits pick the register word |
| wdataIn | input | DATA_W | Write data, valid during the data phase |
| masterIn | input | 3 | Number of the master driving the bus |
| readyIn | input | 1 | Bus-wide ready (previous data phase done) |
| modeIn | input | 2 | Test choice: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| waitIn | input | 6 | Requested wait cycles for an OKAY answer |
| resumeIn | input | 1 | Release the held split master |
| readyOut | output | 1 | Slave ready |
| respOut | output | 2 | Response: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT |
| rdataOut | output | DATA_W | Read data |
| splitVecOut | output | 8 | One-hot release pulse, one bit per master |

## Verification
Some checks run on every cycle. These are the two-cycle shape of every non-OKAY reply, the bound on the wait counter, the absence of split codes in a slave built without the capability, and the retry of a second split request while one is held. The single-cycle, one-hot form of the release pulse, and the rule that a pulse follows a resume, are checked the same way. The scenarios must show the rest. That covers the exact count of wait cycles, the clamp, data that returns after writes, the write that an ignored beat after an error does not make, and the master bit each release lands on. Both builds of the slave run side by side in these scenarios.

// File: rtl/splitSlavePkg.sv
package splitSlavePkg;
  typedef enum logic [1:0] {
    RESP_OKAY  = 2'b00,
    RESP_ERROR = 2'b01,
    RESP_RETRY = 2'b10,
    RESP_SPLIT = 2'b11
  } resp_e;

  localparam logic [1:0] ANS_OKAY  = 2'b00;
  localparam logic [1:0] ANS_ERROR = 2'b01;
  localparam logic [1:0] ANS_RETRY = 2'b10;
  localparam logic [1:0] ANS_SPLIT = 2'b11;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_ERR1, ST_ERR2, ST_RTY1, ST_RTY2, ST_SPL1, ST_SPL2
  } phase_e;

  typedef struct packed {
    logic capture;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/splitSlaveCtrl.sv
module splitSlaveCtrl
  import splitSlavePkg::*;
#(
  parameter int MASTERS   = 8,
  parameter int MID_W     = 3,
  parameter int MAX_WAIT  = 16,
  parameter int REQ_W     = 6,
  parameter int SPLIT_CAP = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selIn,
  input  logic [1:0]         transIn,
  input  logic [MID_W-1:0]   masterIn,
  input  logic               readyIn,
  input  logic [1:0]         modeIn,
  input  logic [REQ_W-1:0]   waitIn,
  input  logic               resumeIn,
  output strobe_t            strobeOut,
  output logic               readyOut,
  output logic [1:0]         respOut,
  output logic [MASTERS-1:0] splitVecOut
);
  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  phase_e            state, nextState;
  logic [CNT_W-1:0]  waitCnt;
  logic [CNT_W-1:0]  waitClamp;
  logic              ignoreSeq;
  logic              accept;
  logic              splitValid;
  logic [MID_W-1:0]  splitOwner;

  assign accept = selIn && readyIn && transIn[1] &&
                  !(transIn == TR_SEQ && ignoreSeq);

  assign waitClamp = (waitIn > REQ_W'(MAX_WAIT)) ? CNT_W'(MAX_WAIT)
                                                 : waitIn[CNT_W-1:0];

  always_comb begin
    nextState = state;
    case (state)
      ST_DATA: if (waitCnt == '0) nextState = ST_IDLE;
      ST_ERR1: nextState = ST_ERR2;
      ST_RTY1: nextState = ST_RTY2;
      ST_SPL1: nextState = ST_SPL2;
      ST_ERR2, ST_RTY2, ST_SPL2: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
    if (accept) begin
      case (modeIn)
        ANS_OKAY:  nextState = ST_DATA;
        ANS_ERROR: nextState = ST_ERR1;
        ANS_RETRY: nextState = ST_RTY1;
        default:   nextState = (SPLIT_CAP != 0 && !splitValid) ? ST_SPL1 : ST_RTY1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      ignoreSeq <= 1'b0;
    end else begin
      state <= nextState;
      if (accept && modeIn == ANS_OKAY)
        waitCnt <= waitClamp;
      else if (state == ST_DATA && waitCnt != '0)
        waitCnt <= waitCnt - 1'b1;
      if (accept && modeIn == ANS_ERROR)
        ignoreSeq <= 1'b1;
      else if (selIn && readyIn && (transIn == TR_IDLE || transIn == TR_NONSEQ))
        ignoreSeq <= 1'b0;
    end
  end

  assign strobeOut.capture = accept;
  assign strobeOut.commit  = (state == ST_DATA) && (waitCnt == '0);

  always_comb begin
    readyOut = 1'b1;
    respOut  = RESP_OKAY;
    case (state)
      ST_DATA: readyOut = (waitCnt == '0);
      ST_ERR1: begin readyOut = 1'b0; respOut = RESP_ERROR; end
      ST_ERR2: respOut = RESP_ERROR;
      ST_RTY1: begin readyOut = 1'b0; respOut = RESP_RETRY; end
      ST_RTY2: respOut = RESP_RETRY;
      ST_SPL1: begin readyOut = 1'b0; respOut = RESP_SPLIT; end
      ST_SPL2: respOut = RESP_SPLIT;
      default: ;
    endcase
  end

  generate
    if (SPLIT_CAP != 0) begin : gSplit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          splitValid  <= 1'b0;
          splitOwner  <= '0;
          splitVecOut <= '0;
        end else begin
          splitVecOut <= '0;
          if (resumeIn && splitValid) begin
            splitVecOut[splitOwner] <= 1'b1;
            splitValid <= 1'b0;
          end else if (accept && modeIn == ANS_SPLIT && !splitValid) begin
            splitValid <= 1'b1;
            splitOwner <= masterIn;
          end
        end
      end
    end else begin : gNoSplit
      assign splitValid  = 1'b0;
      assign splitOwner  = '0;
      assign splitVecOut = '0;

      // R4
      no_split_code_chk: assert property (@(posedge clk) disable iff (!rstN)
        respOut != RESP_SPLIT);
    end
  endgenerate

  // R3
  two_cycle_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && respOut != RESP_OKAY) |=> (readyOut && respOut == $past(respOut)));

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CNT_W'(MAX_WAIT));

  // R6
  held_split_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (splitValid && accept && modeIn == ANS_SPLIT) |=> respOut == RESP_RETRY);

  // R7
  release_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(splitVecOut));

  // R7
  release_after_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (splitVecOut != '0) |-> $past(resumeIn));

  // R8
  release_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (splitVecOut != '0) |=> (splitVecOut == '0));
endmodule

// File: rtl/splitSlaveData.sv
module splitSlaveData
  import splitSlavePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobeIn,
  input  logic              writeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  output logic [DATA_W-1:0] rdataOut
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             phaseWrite;
  logic [IDX_W-1:0] phaseIdx;
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseWrite <= 1'b0;
      phaseIdx   <= '0;
    end else if (strobeIn.capture) begin
      phaseWrite <= writeIn;
      phaseIdx   <= addrIn[IDX_W-1:0];
    end
  end

  generate
    for (genvar w = 0; w < DEPTH; w++) begin : gWord
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          words[w] <= '0;
        else if (strobeIn.commit && phaseWrite && phaseIdx == IDX_W'(w))
          words[w] <= wdataIn;
      end
    end
  endgenerate

  assign rdataOut = words[phaseIdx];

  // R1
  write_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobeIn.commit && phaseWrite && !strobeIn.capture) |=> rdataOut == $past(wdataIn));
endmodule

// File: rtl/splitSlaveResp.sv
module splitSlaveResp
  import splitSlavePkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 8,
  parameter int MASTERS   = 8,
  parameter int MID_W     = 3,
  parameter int MAX_WAIT  = 16,
  parameter int REQ_W     = 6,
  parameter int SPLIT_CAP = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selIn,
  input  logic [1:0]         transIn,
  input  logic               writeIn,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [DATA_W-1:0]  wdataIn,
  input  logic [MID_W-1:0]   masterIn,
  input  logic               readyIn,
  input  logic [1:0]         modeIn,
  input  logic [REQ_W-1:0]   waitIn,
  input  logic               resumeIn,
  output logic               readyOut,
  output logic [1:0]         respOut,
  output logic [DATA_W-1:0]  rdataOut,
  output logic [MASTERS-1:0] splitVecOut
);
  strobe_t strobe;

  splitSlaveCtrl #(
    .MASTERS(MASTERS), .MID_W(MID_W), .MAX_WAIT(MAX_WAIT),
    .REQ_W(REQ_W), .SPLIT_CAP(SPLIT_CAP)
  ) ctrl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .transIn(transIn),
    .masterIn(masterIn), .readyIn(readyIn), .modeIn(modeIn),
    .waitIn(waitIn), .resumeIn(resumeIn), .strobeOut(strobe),
    .readyOut(readyOut), .respOut(respOut), .splitVecOut(splitVecOut)
  );

  splitSlaveData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) data (
    .clk(clk), .rstN(rstN), .strobeIn(strobe), .writeIn(writeIn),
    .addrIn(addrIn), .wdataIn(wdataIn), .rdataOut(rdataOut)
  );
endmodule

// File: tb/splitSlaveResp_test.sv
`timescale 1ns/1ps
module splitSlaveResp_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selIn = 1'b0;
  logic [1:0]  transIn = 2'b00;
  logic        writeIn = 1'b0;
  logic [7:0]  addrIn = '0;
  logic [15:0] wdataIn = '0;
  logic [2:0]  masterIn = '0;
  logic [1:0]  modeIn = '0;
  logic [5:0]  waitIn = '0;
  logic        resumeIn = 1'b0;
  logic        readyIn, readyOut, readyIn2, readyOut2;
  logic [1:0]  respOut, respOut2;
  logic [15:0] rdataOut, rdataOut2;
  logic [7:0]  splitVecOut, splitVecOut2;

  assign readyIn  = readyOut;
  assign readyIn2 = readyOut2;

  always #5 clk = ~clk;

  splitSlaveResp uut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .transIn(transIn), .writeIn(writeIn),
    .addrIn(addrIn), .wdataIn(wdataIn), .masterIn(masterIn), .readyIn(readyIn),
    .modeIn(modeIn), .waitIn(waitIn), .resumeIn(resumeIn), .readyOut(readyOut),
    .respOut(respOut), .rdataOut(rdataOut), .splitVecOut(splitVecOut));

  splitSlaveResp #(.SPLIT_CAP(0)) uutNoSplit (
    .clk(clk), .rstN(rstN), .selIn(selIn), .transIn(transIn), .writeIn(writeIn),
    .addrIn(addrIn), .wdataIn(wdataIn), .masterIn(masterIn), .readyIn(readyIn2),
    .modeIn(modeIn), .waitIn(waitIn), .resumeIn(resumeIn), .readyOut(readyOut2),
    .respOut(respOut2), .rdataOut(rdataOut2), .splitVecOut(splitVecOut2));

  typedef struct {
    logic [1:0]  resp;
    int          low;
    bit          chkData;
    logic [15:0] data;
    string       req;
  } exp_t;

  exp_t        expQ[$];
  int          checks = 0;
  int          fails = 0;
  int          lowCnt = 0;
  int          cycles = 0;
  logic [1:0]  lastResp2 = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // monitor: pops one expected item per finished data phase
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      if (!readyOut) lowCnt++;
      else begin
        exp_t e;
        e = expQ.pop_front();
        lastResp2 = respOut2;
        check(respOut == e.resp, e.req, respOut, e.resp);
        check(lowCnt == e.low, e.req, lowCnt, e.low);
        if (e.chkData) check(rdataOut == e.data, e.req, rdataOut, e.data);
        lowCnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic xfer(input logic [1:0] mode, input logic [5:0] waits, input bit wr,
                      input logic [7:0] addr, input logic [15:0] data, input logic [2:0] mst,
                      input logic [1:0] eResp, input int eLow, input bit eChk,
                      input logic [15:0] eData, input string req);
    exp_t e;
    @(negedge clk);
    selIn = 1'b1; transIn = 2'b10; modeIn = mode; waitIn = waits;
    writeIn = wr; addrIn = addr; masterIn = mst;
    @(posedge clk);
    #1;
    e.resp = eResp; e.low = eLow; e.chkData = eChk; e.data = eData; e.req = req;
    expQ.push_back(e);
    selIn = 1'b0; transIn = 2'b00; wdataIn = data;
    while (expQ.size() != 0) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(readyOut == 1'b1, "R10", readyOut, 1);
    check(respOut == 2'b00, "R10", respOut, 0);
    check(splitVecOut == 8'h00, "R10", splitVecOut, 0);
    rstN = 1'b1;

    // R1 write then read, R2 wait states
    xfer(2'b00, 6'd0, 1'b1, 8'h03, 16'hA5A5, 3'd1, 2'b00, 0, 1'b0, 16'h0, "R1");
    xfer(2'b00, 6'd2, 1'b0, 8'h03, 16'h0, 3'd1, 2'b00, 2, 1'b1, 16'hA5A5, "R2");
    xfer(2'b00, 6'd0, 1'b0, 8'h03, 16'h0, 3'd1, 2'b00, 0, 1'b1, 16'hA5A5, "R1");
    xfer(2'b00, 6'd5, 1'b1, 8'h0E, 16'h1234, 3'd2, 2'b00, 5, 1'b0, 16'h0, "R2");
    xfer(2'b00, 6'd1, 1'b0, 8'h06, 16'h0, 3'd2, 2'b00, 1, 1'b1, 16'h1234, "R1");
    // R9 clamp: 40 requested, 16 served; 16 exactly also 16
    xfer(2'b00, 6'd40, 1'b1, 8'h05, 16'hBEEF, 3'd0, 2'b00, 16, 1'b0, 16'h0, "R9");
    xfer(2'b00, 6'd16, 1'b0, 8'h05, 16'h0, 3'd0, 2'b00, 16, 1'b1, 16'hBEEF, "R9");
    // R3 retry and error answers
    xfer(2'b10, 6'd3, 1'b0, 8'h01, 16'h0, 3'd3, 2'b10, 1, 1'b0, 16'h0, "R3");
    xfer(2'b01, 6'd3, 1'b1, 8'h05, 16'hDEAD, 3'd3, 2'b01, 1, 1'b0, 16'h0, "R3");

    // R5 sequential beat after the error is ignored
    @(negedge clk);
    selIn = 1'b1; transIn = 2'b11; writeIn = 1'b1; addrIn = 8'h05;
    modeIn = 2'b00; waitIn = 6'd3;
    @(posedge clk);
    #1;
    selIn = 1'b0; transIn = 2'b00; wdataIn = 16'hFFFF;
    @(negedge clk);
    check(readyOut == 1'b1, "R5", readyOut, 1);
    check(respOut == 2'b00, "R5", respOut, 0);
    xfer(2'b00, 6'd0, 1'b0, 8'h05, 16'h0, 3'd0, 2'b00, 0, 1'b1, 16'hBEEF, "R5");

    // R3/R4 split by master 6; the plain build answers retry
    xfer(2'b11, 6'd0, 1'b0, 8'h02, 16'h0, 3'd6, 2'b11, 1, 1'b0, 16'h0, "R3");
    check(lastResp2 == 2'b10, "R4", lastResp2, 2'b10);
    // R6 second split while held
    xfer(2'b11, 6'd0, 1'b0, 8'h02, 16'h0, 3'd2, 2'b10, 1, 1'b0, 16'h0, "R6");
    check(splitVecOut == 8'h00, "R7", splitVecOut, 0);

    // R7/R8 release of master 6 with resume held two cycles
    @(negedge clk);
    resumeIn = 1'b1;
    @(negedge clk);
    check(splitVecOut == 8'h40, "R7", splitVecOut, 8'h40);
    @(negedge clk);
    check(splitVecOut == 8'h00, "R8", splitVecOut, 0);
    resumeIn = 1'b0;

    // R8 slave splits again after release, now master 2
    xfer(2'b11, 6'd0, 1'b0, 8'h02, 16'h0, 3'd2, 2'b11, 1, 1'b0, 16'h0, "R8");
    @(negedge clk);
    resumeIn = 1'b1;
    @(negedge clk);
    resumeIn = 1'b0;
    check(splitVecOut == 8'h04, "R7", splitVecOut, 8'h04);

    // R7 resume with nothing held gives no pulse
    @(negedge clk);
    resumeIn = 1'b1;
    @(negedge clk);
    resumeIn = 1'b0;
    check(splitVecOut == 8'h00, "R7", splitVecOut, 0);
    check(splitVecOut2 == 8'h00, "R4", splitVecOut2, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule